// File: doc/BRIEF.md
# Framed Serial Control and Signalling Port

This block terminates a framed, bit-serial, bidirectional system port that carries two byte-wide time slots in every frame. A frame holds 32 channels of 8 bits. A one-clock frame pulse marks the first bit of channel 0. One slot is the control slot (C). Its incoming byte is routed by its two low bits to either a control register or a diagnostics register. The other slot is the signalling slot (D). Its incoming byte is reduced to the D bits that the selected line rate actually carries, and those bits are then presented to the line side.

On the serial output the block returns a status byte in the C slot. In the D slot it returns the D bits received from the line, with the unused positions filled with 1. Both bytes go out in the same bit times as the incoming bytes of the same slots. A slot-order input decides whether C or D comes first in the frame. The second slot always starts fifteen channel times after the first. The control register also holds the line-rate, D-in-B1, prescrambler-enable, attack and housekeeping controls for the rest of the line interface. One control bit arms a one-shot diagnostics reset that takes effect only at the following frame pulse.

Top module: `cdp_serial_port`

## Requirements
- R1: Following synchronous reset: rate select, D-in-B1 flag, prescrambler enable, attack and housekeeping outputs are 0. The diagnostics register is 0, the line D strobe is low and `sdo` is 1.
- R2: `frame_pulse` marks bit 7 (MSB) of channel 0. Each frame is 32 channels of 8 bits, sent MSB first. With `swap_order`=0 the C slot is channel 0 and the D slot is channel 15. Exactly one line D strobe is produced per D slot.
- R3: With `swap_order`=1 the D slot is channel 0 and the C slot is channel 15. The two slots never overlap.
- R4: A C byte whose bits [1:0] are 00 is written to the control register. Its fields are: bit 3 line rate (0 = 80 kbit/s, 1 = 160 kbit/s), bit 4 D-in-B1, bit 5 prescrambler enable, bit 6 attack, bit 7 housekeeping. The new values appear in the cycle after the slot's last bit and change at no other time.
- R5: A C byte whose bit 0 is 0 and bit 1 is 1 (bits [1:0] = 2'b10) is written whole to the diagnostics register. C bytes with bits [1:0] equal to 01 or 11 change neither register.
- R6: A control write with bit 2 = 0 clears the diagnostics register in the cycle after the next frame pulse. A control write with bit 2 = 1 leaves it untouched.
- R7: At 80 kbit/s with D-in-B1 off, the received D byte yields `line_d_out` = {7'b0, D0}. `line_d_strobe` pulses for one cycle in the cycle after the slot's last bit.
- R8: At 160 kbit/s with D-in-B1 off, `line_d_out` carries D1 and D0 in bits [1:0]. All other bits are 0.
- R9: With D-in-B1 on, all eight D bits appear on `line_d_out`, whatever the rate.
- R10: In the C slot, `sdo` sends `stat_byte` MSB first. The byte is sampled in the slot's first bit time, and each bit goes out in the same cycle as the matching input bit.
- R11: In the D slot, `sdo` sends `line_d_in`. Positions outside the active D bits (same masks as R7–R9) are sent as 1.
- R12: Outside both slots, and before the first frame pulse, `sdo` is 1. Before the first frame pulse no register or line output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-cycle marker of bit 7 of channel 0 |
| sdi | input | 1 | Serial data from the system |
| swap_order | input | 1 | 0: C then D, 1: D then C |
| stat_byte | input | 8 | Status byte returned in the C slot |
| line_d_in | input | 8 | D bits received from the line |
| sdo | output | 1 | Serial data to the system |
| ctrl_rate160 | output | 1 | Line rate select, 1 = 160 kbit/s |
| ctrl_d_in_b | output | 1 | D bits carried in the B1 slot |
| ctrl_psen | output | 1 | Prescrambler/descrambler enable |
| ctrl_attack | output | 1 | Attack control |
| ctrl_housekeep | output | 1 | Housekeeping bit for the line |
| diag_reg | output | 8 | Diagnostics register |
| line_d_out | output | 8 | Masked D bits for the line |
| line_d_strobe | output | 1 | One-cycle valid for line_d_out |

## Verification
A wrong frame position shows up on `sdo` within the same bit time, because the bench predicts every serial output bit from its own channel count. A wrong register route or wrong rate mask shows up one cycle after the slot's last bit, on the control outputs, `diag_reg` or `line_d_out`. It shows again in the next D slot through the fill bits on `sdo`. A lost or spurious diagnostics reset is visible one cycle after the following frame pulse. The stimulus walks through both slot orders, all four select codes and all three D widths.

// File: rtl/cdp_pkg.sv
package cdp_pkg;
    localparam int BYTE_W  = 8;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int CHANS   = 32;
    localparam int SLOT_GAP = 15;
    localparam int FRAME_BITS = CHANS * BYTE_W;
    localparam int CNT_W   = $clog2(FRAME_BITS);
    localparam int CH_W    = CNT_W - BIT_W;

    localparam logic [1:0] SEL_CTRL = 2'b00;
    localparam logic [1:0] SEL_DIAG = 2'b10;

    typedef struct packed {
        logic housekeep;
        logic attack;
        logic psen;
        logic d_in_b;
        logic rate160;
        logic diag_keep;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{housekeep: 1'b0, attack: 1'b0, psen: 1'b0,
                                   d_in_b: 1'b0, rate160: 1'b0, diag_keep: 1'b1};

    function automatic logic [BYTE_W-1:0] lane_mask(input logic d_in_b, input logic rate160);
        if (d_in_b)       return '1;
        else if (rate160) return BYTE_W'(3);
        else              return BYTE_W'(1);
    endfunction
endpackage

// File: rtl/cdp_frame_timer.sv
module cdp_frame_timer
    import cdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_pulse,
    input  logic             swap_order,
    output logic             slot_c,
    output logic             slot_d,
    output logic             slot_first,
    output logic             slot_last,
    output logic [BIT_W-1:0] bit_idx
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pos;
    logic             locked_q;
    logic             active;
    logic [CH_W-1:0]  chan;
    logic [CH_W-1:0]  c_chan;
    logic [CH_W-1:0]  d_chan;

    assign pos    = frame_pulse ? '0 : cnt_q;
    assign active = locked_q | frame_pulse;
    assign chan   = pos[CNT_W-1:BIT_W];
    assign bit_idx = pos[BIT_W-1:0];
    assign c_chan = swap_order ? CH_W'(SLOT_GAP) : '0;
    assign d_chan = swap_order ? '0 : CH_W'(SLOT_GAP);

    assign slot_c     = active && (chan == c_chan);
    assign slot_d     = active && (chan == d_chan);
    assign slot_first = (bit_idx == '0);
    assign slot_last  = (bit_idx == BIT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            cnt_q    <= (pos == CNT_W'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;
            locked_q <= active;
        end
    end
endmodule

// File: rtl/cdp_rx_deser.sv
module cdp_rx_deser
    import cdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-2:0] hist_q;

    assign rx_byte = {hist_q, sdi};

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= rx_byte[BYTE_W-2:0];
    end
endmodule

// File: rtl/cdp_reg_decode.sv
module cdp_reg_decode
    import cdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_pulse,
    input  logic              c_done,
    input  logic              d_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] diag_q,
    output logic              clr_pend_q,
    output logic [BYTE_W-1:0] d_out_q,
    output logic              d_stb_q
);
    logic [1:0] sel;
    ctrl_t      rx_ctrl;

    assign sel     = rx_byte[1:0];
    assign rx_ctrl = ctrl_t'(rx_byte[BYTE_W-1:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= CTRL_RST;
            diag_q     <= '0;
            clr_pend_q <= 1'b0;
            d_out_q    <= '0;
            d_stb_q    <= 1'b0;
        end else begin
            d_stb_q <= d_done;
            if (frame_pulse && clr_pend_q) begin
                diag_q     <= '0;
                clr_pend_q <= 1'b0;
            end
            if (c_done) begin
                if (sel == SEL_CTRL) begin
                    ctrl_q     <= rx_ctrl;
                    clr_pend_q <= ~rx_ctrl.diag_keep;
                end else if (sel == SEL_DIAG) begin
                    diag_q <= rx_byte;
                end
            end
            if (d_done)
                d_out_q <= rx_byte & lane_mask(ctrl_q.d_in_b, ctrl_q.rate160);
        end
    end
endmodule

// File: rtl/cdp_tx_ser.sv
module cdp_tx_ser
    import cdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_c,
    input  logic              slot_d,
    input  logic              slot_first,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [BYTE_W-1:0] stat_byte,
    input  logic [BYTE_W-1:0] line_d_in,
    input  logic              d_in_b,
    input  logic              rate160,
    output logic              sdo
);
    logic [BYTE_W-1:0] load_byte;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] mask;

    assign mask      = lane_mask(d_in_b, rate160);
    assign load_byte = slot_c ? stat_byte : ((line_d_in & mask) | ~mask);

    always_comb begin
        if (!(slot_c || slot_d))
            sdo = 1'b1;
        else if (slot_first)
            sdo = load_byte[BYTE_W-1];
        else
            sdo = hold_q[BIT_W'(BYTE_W - 1) - bit_idx];
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '1;
        else if ((slot_c || slot_d) && slot_first)
            hold_q <= load_byte;
    end
endmodule

// File: rtl/cdp_serial_port.sv
module cdp_serial_port
    import cdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_pulse,
    input  logic              sdi,
    input  logic              swap_order,
    input  logic [BYTE_W-1:0] stat_byte,
    input  logic [BYTE_W-1:0] line_d_in,
    output logic              sdo,
    output logic              ctrl_rate160,
    output logic              ctrl_d_in_b,
    output logic              ctrl_psen,
    output logic              ctrl_attack,
    output logic              ctrl_housekeep,
    output logic [BYTE_W-1:0] diag_reg,
    output logic [BYTE_W-1:0] line_d_out,
    output logic              line_d_strobe
);
    logic              slot_c;
    logic              slot_d;
    logic              slot_first;
    logic              slot_last;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] rx_byte;
    logic              c_done;
    logic              d_done;
    logic              diag_pend;
    ctrl_t             ctrl;

    assign c_done = slot_c && slot_last;
    assign d_done = slot_d && slot_last;

    cdp_frame_timer u_timer (
        .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .swap_order(swap_order),
        .slot_c(slot_c), .slot_d(slot_d), .slot_first(slot_first),
        .slot_last(slot_last), .bit_idx(bit_idx)
    );

    cdp_rx_deser u_rx (
        .clk(clk), .rst(rst), .sdi(sdi), .rx_byte(rx_byte)
    );

    cdp_reg_decode u_dec (
        .clk(clk), .rst(rst), .frame_pulse(frame_pulse),
        .c_done(c_done), .d_done(d_done), .rx_byte(rx_byte),
        .ctrl_q(ctrl), .diag_q(diag_reg), .clr_pend_q(diag_pend),
        .d_out_q(line_d_out), .d_stb_q(line_d_strobe)
    );

    cdp_tx_ser u_tx (
        .clk(clk), .rst(rst), .slot_c(slot_c), .slot_d(slot_d),
        .slot_first(slot_first), .bit_idx(bit_idx),
        .stat_byte(stat_byte), .line_d_in(line_d_in),
        .d_in_b(ctrl.d_in_b), .rate160(ctrl.rate160), .sdo(sdo)
    );

    assign ctrl_rate160   = ctrl.rate160;
    assign ctrl_d_in_b    = ctrl.d_in_b;
    assign ctrl_psen      = ctrl.psen;
    assign ctrl_attack    = ctrl.attack;
    assign ctrl_housekeep = ctrl.housekeep;
endmodule

// File: rtl/cdp_serial_port_chk.sv
module cdp_serial_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_pulse,
    input logic       slot_c,
    input logic       slot_d,
    input logic       c_done,
    input logic       diag_pend,
    input logic       sdo,
    input logic       ctrl_rate160,
    input logic       ctrl_d_in_b,
    input logic       ctrl_psen,
    input logic       ctrl_attack,
    input logic       ctrl_housekeep,
    input logic [7:0] diag_reg,
    input logic [7:0] line_d_out,
    input logic       line_d_strobe
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !(slot_c || slot_d) |-> sdo); // R12

    AST_SLOTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(slot_c && slot_d)); // R3

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !c_done |=> $stable({ctrl_rate160, ctrl_d_in_b, ctrl_psen, ctrl_attack, ctrl_housekeep})); // R4

    AST_DIAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && diag_pend) |=> (diag_reg == 8'h00)); // R6

    AST_MASK_NARROW: assert property (@(posedge clk) disable iff (rst)
        (line_d_strobe && !ctrl_d_in_b && !ctrl_rate160) |-> (line_d_out[7:1] == 7'h00)); // R7

    AST_MASK_WIDE: assert property (@(posedge clk) disable iff (rst)
        (line_d_strobe && !ctrl_d_in_b && ctrl_rate160) |-> (line_d_out[7:2] == 6'h00)); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_d_strobe |=> !line_d_strobe); // R2
endmodule

bind cdp_serial_port cdp_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .frame_pulse(frame_pulse),
    .slot_c(slot_c), .slot_d(slot_d), .c_done(c_done), .diag_pend(diag_pend),
    .sdo(sdo), .ctrl_rate160(ctrl_rate160), .ctrl_d_in_b(ctrl_d_in_b),
    .ctrl_psen(ctrl_psen), .ctrl_attack(ctrl_attack), .ctrl_housekeep(ctrl_housekeep),
    .diag_reg(diag_reg), .line_d_out(line_d_out), .line_d_strobe(line_d_strobe)
);

// File: tb/cdp_serial_port_test.sv
`timescale 1ns/1ps
module cdp_serial_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_pulse = 1'b0;
    logic       sdi = 1'b1;
    logic       swap_order = 1'b0;
    logic [7:0] stat_byte = 8'h00;
    logic [7:0] line_d_in = 8'h00;
    logic       sdo;
    logic       ctrl_rate160, ctrl_d_in_b, ctrl_psen, ctrl_attack, ctrl_housekeep;
    logic [7:0] diag_reg, line_d_out;
    logic       line_d_strobe;

    int vectors = 0;
    int miscompares = 0;
    bit started = 0;

    // reference model state
    int  m_cnt = 0;
    bit  m_locked = 0;
    int  m_ctrl = 8'h04;
    int  m_diag = 0;
    bit  m_pend = 0;
    int  m_acc = 0;
    int  m_lat = 255;
    int  m_dout = 0;
    bit  m_stb = 0;

    cdp_serial_port uut (
        .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .sdi(sdi),
        .swap_order(swap_order), .stat_byte(stat_byte), .line_d_in(line_d_in),
        .sdo(sdo), .ctrl_rate160(ctrl_rate160), .ctrl_d_in_b(ctrl_d_in_b),
        .ctrl_psen(ctrl_psen), .ctrl_attack(ctrl_attack), .ctrl_housekeep(ctrl_housekeep),
        .diag_reg(diag_reg), .line_d_out(line_d_out), .line_d_strobe(line_d_strobe)
    );

    always #2 clk = ~clk;

    function automatic int mask_of(int c);
        if ((c >> 4) & 1) return 255;
        if ((c >> 3) & 1) return 3;
        return 1;
    endfunction

    function automatic int cur_pos();
        if (frame_pulse) return 0;
        if (m_locked) return m_cnt;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_locked = 0; m_ctrl = 8'h04; m_diag = 0; m_pend = 0;
            m_dout = 0; m_stb = 0; m_lat = 255;
        end else begin
            int p, ch, b, cc, dc, m;
            p = cur_pos();
            m_stb = 0;
            if (frame_pulse && m_pend) begin m_diag = 0; m_pend = 0; end
            if (p >= 0) begin
                m_locked = 1;
                ch = p / 8; b = p % 8;
                cc = swap_order ? 15 : 0;
                dc = swap_order ? 0 : 15;
                m = mask_of(m_ctrl);
                if (ch == cc || ch == dc) begin
                    m_acc = (b == 0) ? int'(sdi) : ((m_acc * 2) + int'(sdi)) & 255;
                    if (b == 0)
                        m_lat = (ch == cc) ? int'(stat_byte)
                                           : ((int'(line_d_in) & m) | (255 & ~m));
                    if (b == 7 && ch == cc) begin
                        if ((m_acc & 3) == 0) begin
                            m_ctrl = m_acc;
                            m_pend = ((m_acc >> 2) & 1) == 0;
                        end else if ((m_acc & 3) == 2) begin
                            m_diag = m_acc;
                        end
                    end
                    if (b == 7 && ch == dc) begin
                        m_stb = 1;
                        m_dout = m_acc & m;
                    end
                end
                m_cnt = (p + 1) % 256;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp, input string what);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            int p, ch, b, cc, dc, m, exp_sdo, byte_now;
            vectors++;
            exp_sdo = 1;
            p = rst ? -1 : cur_pos();
            if (p >= 0) begin
                ch = p / 8; b = p % 8;
                cc = swap_order ? 15 : 0;
                dc = swap_order ? 0 : 15;
                m = mask_of(m_ctrl);
                if (ch == cc || ch == dc) begin
                    if (b == 0) byte_now = (ch == cc) ? int'(stat_byte)
                                                      : ((int'(line_d_in) & m) | (255 & ~m));
                    else byte_now = m_lat;
                    exp_sdo = (byte_now >> (7 - b)) & 1;
                    if (ch == cc) check("R10", int'(sdo), exp_sdo, "sdo in C slot");
                    else          check("R11", int'(sdo), exp_sdo, "sdo in D slot");
                end else begin
                    check("R12", int'(sdo), 1, "idle sdo");
                end
            end else begin
                check("R12", int'(sdo), 1, "sdo before frame lock");
            end
            check("R4", int'({ctrl_housekeep, ctrl_attack, ctrl_psen, ctrl_d_in_b, ctrl_rate160}),
                  (m_ctrl >> 3) & 31, "control fields");
            check("R5", int'(diag_reg), m_diag, "diagnostics register");
            check("R2", int'(line_d_strobe), int'(m_stb), "line D strobe");
            check("R7", int'(line_d_out), m_dout, "line D bits");
        end
    end

    task automatic send_frame(input logic [7:0] cb, input logic [7:0] db,
                              input logic [7:0] st, input logic [7:0] ld, input logic sw);
        for (int p = 0; p < 256; p++) begin
            int ch, b, cc, dc;
            @(posedge clk); #1;
            frame_pulse = (p == 0);
            swap_order = sw;
            stat_byte = st;
            line_d_in = ld;
            ch = p / 8; b = p % 8;
            cc = sw ? 15 : 0;
            dc = sw ? 0 : 15;
            if (ch == cc)      sdi = cb[7 - b];
            else if (ch == dc) sdi = db[7 - b];
            else               sdi = p[0];
        end
    endtask

    initial begin
        #(4 * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1; rst = 1'b0;
        started = 1;
        @(negedge clk);
        // R1: explicit reset state
        vectors++;
        check("R1", int'({ctrl_housekeep, ctrl_attack, ctrl_psen, ctrl_d_in_b, ctrl_rate160}), 0, "reset control");
        check("R1", int'(diag_reg), 0, "reset diag");
        check("R1", int'(sdo), 1, "reset sdo");
        check("R1", int'(line_d_strobe), 0, "reset strobe");
        // R12: serial traffic with a control-select pattern before any frame pulse
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            sdi = (i % 8) > 4 ? 1'b0 : 1'b1;
        end
        // R5 diag write; R7 narrow D at 80 kbit/s
        send_frame(8'h5A, 8'hA7, 8'hC3, 8'h00, 1'b0);
        // R4 control write, R6 reset armed (bit2=0), R8 two D bits
        send_frame(8'hE8, 8'h56, 8'h3C, 8'h02, 1'b0);
        // R6 diag cleared at this frame pulse; R5 select 11 ignored
        send_frame(8'h13, 8'hFF, 8'h81, 8'hFD, 1'b0);
        // R5 diag write again
        send_frame(8'h9E, 8'h41, 8'h7E, 8'h55, 1'b0);
        // R3 swapped order; R9 D-in-B1 full byte, bit2=1 no reset
        send_frame(8'h1C, 8'h3C, 8'hA5, 8'h96, 1'b1);
        // R3 / R5 select 01 ignored; R6 diag kept
        send_frame(8'h01, 8'hC3, 8'h0F, 8'h69, 1'b1);
        // back to defaults (R4)
        send_frame(8'h04, 8'h80, 8'hF0, 8'h01, 1'b0);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            frame_pulse = 1'b0;
            sdi = 1'b1;
        end
        @(negedge clk); #1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule